// File: doc/BRIEF.md
# Delayed-Branch Redirect Unit

This block resolves branches for a pipelined VLIW core whose branches take effect after five delay slots. In the cycle a branch issues, the unit forms its destination and parks it in a short shift pipeline. Exactly five cycles later it raises a one-cycle redirect strobe with the destination for the fetch stage. The instructions already fetched behind the branch run on undisturbed, and instruction fetch and the register file lie outside the block.

A destination comes from one of two sources. The first is a signed word displacement added to the start of the eight-word fetch packet that holds the branch. The second is a register operand sampled at issue, so a later write to that register in the delay slots cannot move the branch. Up to `LANES` branch slots can issue in one cycle. Each slot carries its own strobe, predicate, operand field, address and register value.

If several slots fire in the same cycle, their branches would mature together. The highest-numbered slot, which is the later one in issue order, supplies the destination, and a collision flag rides along with that redirect.

Top module: `dslot_redirect`

## Requirements
- R1: A qualified branch sampled at the clock edge that closes cycle i produces `redirect_o` high during cycle i+5 only, which is five rising edges after and including the issue edge, and for exactly one cycle.
- R2: When bit 0 of a slot's operand field is 0, the target is the branch address with its low 5 bits cleared plus the 21-bit signed displacement in operand bits 21:1 multiplied by 4. The arithmetic is modulo 2^32.
- R3: When bit 0 of the operand field is 1, the target is the slot's register value as sampled at issue, with bits 1:0 forced to zero. Changes to the register input after issue have no effect.
- R4: A slot whose strobe is high but whose predicate is low enters nothing into the pipeline and causes no redirect.
- R5: Branches issued in consecutive cycles each produce their own redirect in consecutive cycles, in issue order and with their own targets.
- R6: When two or more slots fire in the same cycle, the highest-numbered slot's target is used. `collide_o` is high together with that redirect. A lone branch leaves `collide_o` low.
- R7: While `redirect_o` is low, `redirect_tgt_o` is zero and `collide_o` is low.
- R8: A synchronous reset clears every pending branch. No redirect occurs during reset or in the five cycles after it is released.
- R9: The displacement's extremes are honoured with sign extension. The largest positive value reaches base + 0x3FFFFC, and the most negative value reaches base − 0x400000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| br_issue_i | input | LANES | Branch issue strobe per slot |
| br_pred_i | input | LANES | Predicate per slot; 1 lets the branch take effect |
| br_op_i | input | LANES*22 | Per slot: bit 0 selects the source (0 displacement, 1 register), bits 21:1 hold the displacement |
| br_pc_i | input | LANES*32 | Byte address of each slot's branch instruction |
| br_reg_i | input | LANES*32 | Register operand per slot |
| redirect_o | output | 1 | Fetch redirect strobe |
| redirect_tgt_o | output | 32 | Redirect target byte address |
| collide_o | output | 1 | Several branches matured together |

## Verification
A stage that loses or duplicates its valid bit shows at the ports as a missing, early, late or doubled redirect. The timing stimulus checks the strobe on each of the five cycles after issue, so a shift of one cycle is caught in the cycle it occurs. A wrong base mask, sign extension or shift changes `redirect_tgt_o` in the redirect cycle itself. Any of these faults would be seen within six cycles of the branch that exposes it. A target that still follows the register input after issue appears only in the redirect cycle, which is why the bench rewrites that input during the delay slots. A stale slot left over after reset would show as a redirect inside the quiet window that follows reset.

// File: rtl/dslot_pkg.sv
package dslot_pkg;
   timeunit 1ns;
   timeprecision 1ps;

   // destination source encoded in bit 0 of a slot's operand field
   typedef enum logic {
      TSRC_PCREL = 1'b0,
      TSRC_REG   = 1'b1
   } tsrc_e;

   localparam int unsigned DEF_ADDR_W     = 32;
   localparam int unsigned DEF_DISP_W     = 21;
   localparam int unsigned DEF_WORD_BYTES = 4;
   localparam int unsigned DEF_PKT_WORDS  = 8;
   localparam int unsigned DEF_DELAY      = 5;
   localparam int unsigned DEF_LANES      = 2;
endpackage

// File: rtl/dslot_tgt_calc.sv
module dslot_tgt_calc
   import dslot_pkg::*;
#(
   parameter int unsigned ADDR_W     = DEF_ADDR_W,
   parameter int unsigned DISP_W     = DEF_DISP_W,
   parameter int unsigned WORD_BYTES = DEF_WORD_BYTES,
   parameter int unsigned PKT_WORDS  = DEF_PKT_WORDS,
   parameter bit          PKT_REL    = 1'b1,
   localparam int unsigned OP_W      = DISP_W + 1
) (
   input  logic [OP_W-1:0]   op_i,
   input  logic [ADDR_W-1:0] pc_i,
   input  logic [ADDR_W-1:0] reg_i,
   output logic [ADDR_W-1:0] tgt_o
);
   localparam int unsigned WORD_SH = $clog2(WORD_BYTES);
   localparam int unsigned PKT_SH  = $clog2(PKT_WORDS * WORD_BYTES);
   localparam logic [ADDR_W-1:0] WORD_MASK = ~((ADDR_W'(1) << WORD_SH) - ADDR_W'(1));
   localparam logic [ADDR_W-1:0] PKT_MASK  = ~((ADDR_W'(1) << PKT_SH) - ADDR_W'(1));

   tsrc_e               src;
   logic [DISP_W-1:0]   disp;
   logic [ADDR_W-1:0]   disp_ext;
   logic [ADDR_W-1:0]   byte_off;
   logic [ADDR_W-1:0]   base;
   logic [ADDR_W-1:0]   rel_tgt;
   logic [ADDR_W-1:0]   reg_tgt;

   assign src      = tsrc_e'(op_i[0]);
   assign disp     = op_i[OP_W-1:1];
   assign disp_ext = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
   assign byte_off = disp_ext << WORD_SH;

   // base variant: start of the fetch packet, or the branch's own address
   generate
      if (PKT_REL) begin : g_pkt_base
         assign base = pc_i & PKT_MASK;
      end else begin : g_own_base
         assign base = pc_i;
      end
   endgenerate

   assign rel_tgt = base + byte_off;
   assign reg_tgt = reg_i & WORD_MASK;

   always_comb begin
      unique case (src)
         TSRC_PCREL: tgt_o = rel_tgt;
         TSRC_REG:   tgt_o = reg_tgt;
         default:    tgt_o = '0;
      endcase
   end
endmodule

// File: rtl/dslot_lane_merge.sv
module dslot_lane_merge #(
   parameter int unsigned LANES  = 2,
   parameter int unsigned ADDR_W = 32
) (
   input  logic [LANES-1:0]  fire_i,
   input  logic [ADDR_W-1:0] tgt_i [LANES],
   output logic              any_o,
   output logic              multi_o,
   output logic [ADDR_W-1:0] tgt_o
);
   // later slot in issue order overrides earlier ones
   always_comb begin
      any_o   = 1'b0;
      multi_o = 1'b0;
      tgt_o   = '0;
      for (int l = 0; l < LANES; l++) begin
         if (fire_i[l]) begin
            multi_o = multi_o | any_o;
            any_o   = 1'b1;
            tgt_o   = tgt_i[l];
         end
      end
   end
endmodule

// File: rtl/dslot_delay_line.sv
module dslot_delay_line #(
   parameter int unsigned DELAY  = 5,
   parameter int unsigned ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              vld_i,
   input  logic              col_i,
   input  logic [ADDR_W-1:0] tgt_i,
   output logic              vld_o,
   output logic              col_o,
   output logic [ADDR_W-1:0] tgt_o
);
   typedef struct packed {
      logic              vld;
      logic              col;
      logic [ADDR_W-1:0] tgt;
   } slot_t;

   slot_t entry;
   slot_t pipe [DELAY];

   // empty slots carry a zero target so the output is quiet between redirects
   assign entry.vld = vld_i;
   assign entry.col = vld_i & col_i;
   assign entry.tgt = vld_i ? tgt_i : '0;

   generate
      for (genvar k = 0; k < DELAY; k++) begin : g_stage
         if (k == 0) begin : g_head
            always_ff @(posedge clk) begin
               if (rst) pipe[k] <= '0;
               else     pipe[k] <= entry;
            end
         end else begin : g_body
            always_ff @(posedge clk) begin
               if (rst) pipe[k] <= '0;
               else     pipe[k] <= pipe[k-1];
            end
         end
      end
   endgenerate

   assign vld_o = pipe[DELAY-1].vld;
   assign col_o = pipe[DELAY-1].col;
   assign tgt_o = pipe[DELAY-1].tgt;
endmodule

// File: rtl/dslot_redirect.sv
module dslot_redirect
   import dslot_pkg::*;
#(
   parameter int unsigned LANES      = DEF_LANES,
   parameter int unsigned ADDR_W     = DEF_ADDR_W,
   parameter int unsigned DISP_W     = DEF_DISP_W,
   parameter int unsigned WORD_BYTES = DEF_WORD_BYTES,
   parameter int unsigned PKT_WORDS  = DEF_PKT_WORDS,
   parameter int unsigned DELAY      = DEF_DELAY,
   parameter bit          PKT_REL    = 1'b1,
   localparam int unsigned OP_W      = DISP_W + 1
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [LANES-1:0]        br_issue_i,
   input  logic [LANES-1:0]        br_pred_i,
   input  logic [LANES*OP_W-1:0]   br_op_i,
   input  logic [LANES*ADDR_W-1:0] br_pc_i,
   input  logic [LANES*ADDR_W-1:0] br_reg_i,
   output logic                    redirect_o,
   output logic [ADDR_W-1:0]       redirect_tgt_o,
   output logic                    collide_o
);
   localparam int unsigned WORD_SH = $clog2(WORD_BYTES);

   // elaboration-time parameter checks
   generate
      if (LANES < 1) begin : g_bad_lanes
         $error("dslot_redirect: LANES must be at least 1");
      end
      if (DELAY < 1) begin : g_bad_delay
         $error("dslot_redirect: DELAY must be at least 1");
      end
      if (DISP_W + WORD_SH >= ADDR_W) begin : g_bad_disp
         $error("dslot_redirect: displacement too wide for the address");
      end
      if ((WORD_BYTES & (WORD_BYTES - 1)) != 0) begin : g_bad_word
         $error("dslot_redirect: WORD_BYTES must be a power of two");
      end
      if ((PKT_WORDS & (PKT_WORDS - 1)) != 0) begin : g_bad_pkt
         $error("dslot_redirect: PKT_WORDS must be a power of two");
      end
   endgenerate

   logic [LANES-1:0]  fire;
   logic [ADDR_W-1:0] lane_tgt [LANES];
   logic              m_any;
   logic              m_multi;
   logic [ADDR_W-1:0] m_tgt;

   assign fire = br_issue_i & br_pred_i;

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         dslot_tgt_calc #(
            .ADDR_W    (ADDR_W),
            .DISP_W    (DISP_W),
            .WORD_BYTES(WORD_BYTES),
            .PKT_WORDS (PKT_WORDS),
            .PKT_REL   (PKT_REL)
         ) u_calc (
            .op_i (br_op_i [l*OP_W   +: OP_W]),
            .pc_i (br_pc_i [l*ADDR_W +: ADDR_W]),
            .reg_i(br_reg_i[l*ADDR_W +: ADDR_W]),
            .tgt_o(lane_tgt[l])
         );
      end
   endgenerate

   dslot_lane_merge #(
      .LANES (LANES),
      .ADDR_W(ADDR_W)
   ) u_merge (
      .fire_i (fire),
      .tgt_i  (lane_tgt),
      .any_o  (m_any),
      .multi_o(m_multi),
      .tgt_o  (m_tgt)
   );

   dslot_delay_line #(
      .DELAY (DELAY),
      .ADDR_W(ADDR_W)
   ) u_line (
      .clk  (clk),
      .rst  (rst),
      .vld_i(m_any),
      .col_i(m_multi),
      .tgt_i(m_tgt),
      .vld_o(redirect_o),
      .col_o(collide_o),
      .tgt_o(redirect_tgt_o)
   );
endmodule

// File: rtl/dslot_redirect_chk.sv
module dslot_redirect_chk #(
   parameter int unsigned LANES  = 2,
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DELAY  = 5
) (
   input logic              clk,
   input logic              rst,
   input logic [LANES-1:0]  br_issue_i,
   input logic [LANES-1:0]  br_pred_i,
   input logic              redirect_o,
   input logic [ADDR_W-1:0] redirect_tgt_o,
   input logic              collide_o
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int unsigned CW = $clog2(DELAY + 1);

   logic [LANES-1:0] q_fire;
   logic             q_any;
   logic             q_multi;
   logic [DELAY-1:0] h_any;
   logic [DELAY-1:0] h_multi;
   logic [CW-1:0]    since_rst;

   assign q_fire  = br_issue_i & br_pred_i;
   assign q_any   = |q_fire;
   assign q_multi = $countones(q_fire) > 1;

   // history of qualified issues, one bit per cycle since issue
   always_ff @(posedge clk) begin
      if (rst) begin
         h_any     <= '0;
         h_multi   <= '0;
         since_rst <= '0;
      end else begin
         h_any   <= {h_any[DELAY-2:0], q_any};
         h_multi <= {h_multi[DELAY-2:0], q_multi};
         if (since_rst != CW'(DELAY)) since_rst <= since_rst + 1'b1;
      end
   end

   // R1, R4, R5: redirect appears exactly DELAY cycles after a qualified issue
   p_mature_r1: assert property (@(posedge clk) disable iff (rst)
      redirect_o == h_any[DELAY-1]);

   // R6: collision flag travels with the redirect of a multi-slot issue
   p_collide_r6: assert property (@(posedge clk) disable iff (rst)
      collide_o == h_multi[DELAY-1]);

   // R7: idle outputs are quiet
   p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
      !redirect_o |-> (redirect_tgt_o == '0 && !collide_o));

   // R3 and R2: every target is word aligned
   p_word_align_r3: assert property (@(posedge clk) disable iff (rst)
      redirect_o |-> redirect_tgt_o[1:0] == 2'b00);

   // R8: no redirect within DELAY cycles of reset release
   p_quiet_after_reset_r8: assert property (@(posedge clk) disable iff (rst)
      (since_rst < CW'(DELAY)) |-> !redirect_o);

   // R1: a redirect lasts one cycle unless another branch issued next cycle
   p_single_cycle_r1: assert property (@(posedge clk) disable iff (rst)
      (redirect_o && !h_any[DELAY-2]) |=> !redirect_o);
endmodule

bind dslot_redirect dslot_redirect_chk #(
   .LANES (LANES),
   .ADDR_W(ADDR_W),
   .DELAY (DELAY)
) u_chk (
   .clk           (clk),
   .rst           (rst),
   .br_issue_i    (br_issue_i),
   .br_pred_i     (br_pred_i),
   .redirect_o    (redirect_o),
   .redirect_tgt_o(redirect_tgt_o),
   .collide_o     (collide_o)
);

// File: tb/sim_dslot_redirect.sv
module sim_dslot_redirect;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int LANES = 2;
   localparam int AW    = 32;
   localparam int OPW   = 22;
   localparam int NV    = 8;

   // vector table: predicate, source, displacement, branch address, register, expected
   localparam logic        V_PRED [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1};
   localparam logic        V_SEL  [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
   localparam logic [20:0] V_DISP [NV] = '{21'd3, 21'h1FFFFF, 21'h0FFFFF, 21'h100000,
                                            21'h0AAAAA, 21'h155555, 21'd5, 21'd0};
   localparam logic [31:0] V_PC   [NV] = '{32'h0000_1234, 32'h8000_003C, 32'h0000_0010, 32'h0000_0000,
                                            32'h0000_1000, 32'h0000_2000, 32'h0000_0100, 32'h0000_001F};
   localparam logic [31:0] V_REG  [NV] = '{32'h0, 32'h0, 32'h0, 32'h0,
                                            32'h1234_5677, 32'hFFFF_FFFF, 32'h0, 32'h0};
   localparam logic [31:0] V_EXP  [NV] = '{32'h0000_122C, 32'h8000_001C, 32'h003F_FFFC, 32'hFFC0_0000,
                                            32'h1234_5674, 32'hFFFF_FFFC, 32'h0000_0000, 32'h0000_0000};
   localparam string       V_REQ  [NV] = '{"R2", "R2", "R9", "R9", "R3", "R3", "R4", "R2"};

   logic                  clk = 1'b0;
   logic                  rst;
   logic [LANES-1:0]      br_issue_i;
   logic [LANES-1:0]      br_pred_i;
   logic [LANES*OPW-1:0]  br_op_i;
   logic [LANES*AW-1:0]   br_pc_i;
   logic [LANES*AW-1:0]   br_reg_i;
   logic                  redirect_o;
   logic [AW-1:0]         redirect_tgt_o;
   logic                  collide_o;

   int n_vec = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   dslot_redirect u0 (
      .clk           (clk),
      .rst           (rst),
      .br_issue_i    (br_issue_i),
      .br_pred_i     (br_pred_i),
      .br_op_i       (br_op_i),
      .br_pc_i       (br_pc_i),
      .br_reg_i      (br_reg_i),
      .redirect_o    (redirect_o),
      .redirect_tgt_o(redirect_tgt_o),
      .collide_o     (collide_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic set_lane(input int l, input logic iss, input logic prd, input logic sel,
                           input logic [20:0] d, input logic [31:0] pc, input logic [31:0] rv);
      br_issue_i[l]          = iss;
      br_pred_i[l]           = prd;
      br_op_i[l*OPW +: OPW]  = {d, sel};
      br_pc_i[l*AW +: AW]    = pc;
      br_reg_i[l*AW +: AW]   = rv;
   endtask

   task automatic idle_all();
      for (int l = 0; l < LANES; l++) set_lane(l, 1'b0, 1'b0, 1'b0, 21'h0, 32'h0, 32'h0);
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      #(200000 * 4);
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      rst = 1'b1;
      idle_all();
      repeat (3) step();
      // R8: reset state
      chk("R8", {31'h0, redirect_o}, 32'h0);
      chk("R7", redirect_tgt_o, 32'h0);
      chk("R7", {31'h0, collide_o}, 32'h0);
      rst = 1'b0;
      for (int k = 0; k < 5; k++) begin
         step();
         chk("R8", {31'h0, redirect_o}, 32'h0);
      end

      // table walk on slot 0, register rewritten during delay slots (R3)
      for (int i = 0; i < NV; i++) begin
         set_lane(0, 1'b1, V_PRED[i], V_SEL[i], V_DISP[i], V_PC[i], V_REG[i]);
         step();
         set_lane(0, 1'b0, 1'b0, 1'b0, 21'h0, 32'hFFFF_FFE0, 32'hDEAD_BEEF);
         chk("R1", {31'h0, redirect_o}, 32'h0);
         for (int k = 0; k < 3; k++) begin
            step();
            chk("R1", {31'h0, redirect_o}, 32'h0);
         end
         step();
         chk(V_REQ[i], {31'h0, redirect_o}, {31'h0, V_PRED[i]});
         chk(V_REQ[i], redirect_tgt_o, V_EXP[i]);
         chk("R6", {31'h0, collide_o}, 32'h0);
         step();
         chk("R1", {31'h0, redirect_o}, 32'h0);
         chk("R7", redirect_tgt_o, 32'h0);
      end

      // R5: three back-to-back branches
      set_lane(0, 1'b1, 1'b1, 1'b0, 21'd1, 32'h0000_0040, 32'h0);
      step();
      set_lane(0, 1'b1, 1'b1, 1'b1, 21'd0, 32'h0, 32'h2000_0003);
      step();
      set_lane(0, 1'b1, 1'b1, 1'b0, 21'h1FFFFE, 32'h0000_007F, 32'h0);
      step();
      idle_all();
      step();
      step();
      chk("R5", redirect_tgt_o, 32'h0000_0044);
      chk("R5", {31'h0, redirect_o}, 32'h1);
      step();
      chk("R5", redirect_tgt_o, 32'h2000_0000);
      chk("R5", {31'h0, redirect_o}, 32'h1);
      step();
      chk("R5", redirect_tgt_o, 32'h0000_0058);
      chk("R5", {31'h0, redirect_o}, 32'h1);
      step();
      chk("R5", {31'h0, redirect_o}, 32'h0);

      // R6: both slots fire together, slot 1 wins
      set_lane(0, 1'b1, 1'b1, 1'b0, 21'd4, 32'h0000_0100, 32'h0);
      set_lane(1, 1'b1, 1'b1, 1'b1, 21'd0, 32'h0, 32'hABCD_0001);
      step();
      idle_all();
      repeat (4) step();
      chk("R6", {31'h0, redirect_o}, 32'h1);
      chk("R6", redirect_tgt_o, 32'hABCD_0000);
      chk("R6", {31'h0, collide_o}, 32'h1);
      step();
      chk("R7", {31'h0, collide_o}, 32'h0);

      // R4: slot 1 predicated off, slot 0 alone, no collision
      set_lane(0, 1'b1, 1'b1, 1'b0, 21'd4, 32'h0000_0100, 32'h0);
      set_lane(1, 1'b1, 1'b0, 1'b1, 21'd0, 32'h0, 32'hABCD_0001);
      step();
      idle_all();
      repeat (4) step();
      chk("R4", redirect_tgt_o, 32'h0000_0110);
      chk("R4", {31'h0, collide_o}, 32'h0);

      // R4: only a predicated-off branch on slot 1
      set_lane(1, 1'b1, 1'b0, 1'b0, 21'd2, 32'h0000_0200, 32'h0);
      step();
      idle_all();
      for (int k = 0; k < 6; k++) begin
         chk("R4", {31'h0, redirect_o}, 32'h0);
         step();
      end

      // R8: reset flushes a pending branch
      set_lane(0, 1'b1, 1'b1, 1'b0, 21'd8, 32'h0000_0300, 32'h0);
      step();
      idle_all();
      step();
      rst = 1'b1;
      step();
      rst = 1'b0;
      for (int k = 0; k < 6; k++) begin
         step();
         chk("R8", {31'h0, redirect_o}, 32'h0);
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule